// File: doc/BRIEF.md
# Wall-Following Maze Robot Controller

This block is a Moore finite-state controller that steers a small maze robot so that a wall stays on its right-hand side. Two contact antennas report whether the left or the right feeler touches a wall. From these two inputs and its own state, the controller asserts three actuator commands: step forward, nudge left and nudge right. Each command is held high for one clock per step.

The strategy uses five states, and each state has a fixed 3-bit binary code. The robot starts lost and moves forward until it touches something. It then turns left until the wall lies to its right. After that it follows the wall: it drifts left while touching the wall and drifts right when contact is lost. When the wall breaks off, it keeps turning right until it finds the wall again. The command outputs and the state code outputs are decoded from the state register alone, so they change only at a clock edge.

Reset is asserted asynchronously, active low, and released through a small synchronizer. The three codes that no state uses fall back to the lost state.

Top module: `wall_follow_ctrl`

## Requirements
- R1: While rst_n is low the state is LOST (code 000) at once, with no clock needed. After rst_n rises, the machine stays in LOST for the next two rising edges whatever the inputs are. It first moves on the third edge.
- R2: In LOST (000), the machine stays in LOST when both antennas read 0. It moves to WALL_AHEAD (001) when either antenna reads 1.
- R3: In WALL_AHEAD (001), the machine stays while touch_left is 1. With touch_left=0 it goes to HUG (010) if touch_right is 1, or to SEEK (011) if touch_right is 0.
- R4: In HUG (010), touch_left=1 sends the machine to WALL_AHEAD (001). With touch_left=0 it stays in HUG if touch_right is 1, or goes to SEEK (011) if touch_right is 0.
- R5: In SEEK (011), touch_right=1 goes to HUG (010) and touch_right=0 goes to GAP (100). touch_left has no effect.
- R6: In GAP (100), touch_right=1 goes to HUG (010) and touch_right=0 stays in GAP. touch_left has no effect.
- R7: The outputs {fwd, turn_left, turn_right} are decoded from the state: LOST gives 100, WALL_AHEAD gives 010, HUG gives 110, SEEK gives 101 and GAP gives 101. state_code always shows the current 3-bit state code.
- R8: The unused codes 101, 110 and 111 drive all three actuator outputs to 0. On the next rising edge the machine goes to LOST (000).
- R9: The outputs depend on the state only. They change only at a rising clock edge and never follow an input change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| touch_left | input | 1 | Left antenna is in contact with a wall |
| touch_right | input | 1 | Right antenna is in contact with a wall |
| fwd | output | 1 | Step forward |
| turn_left | output | 1 | Turn slightly left |
| turn_right | output | 1 | Turn slightly right |
| state_code | output | 3 | Current state code |

## Verification
The bench applies an antenna pair a half period before a rising edge. The next state and its decoded outputs are due right after that single edge, so the bench samples them 1 ns after the edge and then drives the next pair. Reset entry is checked 1 ns after rst_n falls, with no edge in between. Release is checked edge by edge: the machine must still be in LOST after the first and second edges and must move only on the third. For the unused codes, the bench imposes a code between edges and checks that the outputs are all 0 at once, then checks for LOST one edge later.

// File: rtl/wall_follow_pkg.sv
package wall_follow_pkg;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] ST_LOST       = 3'b000;
  localparam logic [STATE_W-1:0] ST_WALL_AHEAD = 3'b001;
  localparam logic [STATE_W-1:0] ST_HUG        = 3'b010;
  localparam logic [STATE_W-1:0] ST_SEEK       = 3'b011;
  localparam logic [STATE_W-1:0] ST_GAP        = 3'b100;

  typedef struct packed {
    logic fwd;
    logic left;
    logic right;
  } act_t;
endpackage

// File: rtl/wf_rst_sync.sv
module wf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[TOP-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[TOP];
endmodule

// File: rtl/wf_next_state.sv
module wf_next_state
  import wall_follow_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               tl,
  input  logic               tr,
  output logic [STATE_W-1:0] nxt
);
  always_comb begin
    nxt = ST_LOST;
    unique case (cur)
      ST_LOST:       nxt = (tl || tr) ? ST_WALL_AHEAD : ST_LOST;
      ST_WALL_AHEAD: nxt = tl ? ST_WALL_AHEAD : (tr ? ST_HUG : ST_SEEK);
      ST_HUG:        nxt = tl ? ST_WALL_AHEAD : (tr ? ST_HUG : ST_SEEK);
      ST_SEEK:       nxt = tr ? ST_HUG : ST_GAP;
      ST_GAP:        nxt = tr ? ST_HUG : ST_GAP;
      default:       nxt = ST_LOST;
    endcase
  end
endmodule

// File: rtl/wf_state_reg.sv
module wf_state_reg
  import wall_follow_pkg::*;
(
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic [STATE_W-1:0] nxt,
  output logic [STATE_W-1:0] state_q
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_LOST;
    else             state_q <= nxt;
  end

  // R8
  unused_recover_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q > ST_GAP) |=> (state_q == ST_LOST));
endmodule

// File: rtl/wf_out_decode.sv
module wf_out_decode
  import wall_follow_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  output act_t               act
);
  always_comb begin
    act = '0;
    unique case (cur)
      ST_LOST:       act = '{fwd: 1'b1, left: 1'b0, right: 1'b0};
      ST_WALL_AHEAD: act = '{fwd: 1'b0, left: 1'b1, right: 1'b0};
      ST_HUG:        act = '{fwd: 1'b1, left: 1'b1, right: 1'b0};
      ST_SEEK:       act = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
      ST_GAP:        act = '{fwd: 1'b1, left: 1'b0, right: 1'b1};
      default:       act = '0;
    endcase
  end

  // R7
  turn_excl_chk: assert final (!(act.left && act.right));
endmodule

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl
  import wall_follow_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         touch_left,
  input  logic         touch_right,
  output logic         fwd,
  output logic         turn_left,
  output logic         turn_right,
  output logic [2:0]   state_code
);
  logic               rst_sync_n;
  logic [STATE_W-1:0] nxt;
  logic [STATE_W-1:0] cur;
  act_t               act;

  wf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  wf_next_state u_nxt (
    .cur(cur), .tl(touch_left), .tr(touch_right), .nxt(nxt));

  wf_state_reg u_reg (
    .clk(clk), .rst_sync_n(rst_sync_n), .nxt(nxt), .state_q(cur));

  wf_out_decode u_dec (.cur(cur), .act(act));

  assign fwd        = act.fwd;
  assign turn_left  = act.left;
  assign turn_right = act.right;
  assign state_code = cur;

  // R2
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == ST_LOST && !touch_left && !touch_right) |=> (state_code == ST_LOST));

  // R3
  ahead_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == ST_WALL_AHEAD && touch_left) |=> (state_code == ST_WALL_AHEAD));

  // R5
  seek_to_hug_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == ST_SEEK && touch_right) |=> (state_code == ST_HUG));

  // R6
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_code == ST_GAP && !touch_right) |=> (state_code == ST_GAP));

  // R9
  moore_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $stable(state_code) |-> ($stable(fwd) && $stable(turn_left) && $stable(turn_right)));
endmodule

// File: tb/sim_wall_follow_ctrl.sv
module sim_wall_follow_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tl = 1'b0;
  logic tr = 1'b0;
  logic fwd, tleft, tright;
  logic [2:0] st;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wall_follow_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .touch_left(tl), .touch_right(tr),
    .fwd(fwd), .turn_left(tleft), .turn_right(tright), .state_code(st));

  // {touch_left, touch_right, expected state}
  localparam logic [4:0] VEC [21] = '{
    {2'b00, 3'b000}, {2'b01, 3'b001}, {2'b10, 3'b001}, {2'b01, 3'b010},
    {2'b01, 3'b010}, {2'b10, 3'b001}, {2'b00, 3'b011}, {2'b11, 3'b010},
    {2'b00, 3'b011}, {2'b10, 3'b100}, {2'b10, 3'b100}, {2'b00, 3'b100},
    {2'b11, 3'b010}, {2'b00, 3'b011}, {2'b01, 3'b010}, {2'b11, 3'b001},
    {2'b11, 3'b001}, {2'b00, 3'b011}, {2'b00, 3'b100}, {2'b01, 3'b010},
    {2'b00, 3'b011}};

  function automatic logic [2:0] exp_act(input logic [2:0] s);
    case (s)
      3'b000:  return 3'b100;
      3'b001:  return 3'b010;
      3'b010:  return 3'b110;
      3'b011:  return 3'b101;
      3'b100:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [2:0] es, input logic [2:0] ea);
    checks++;
    if (st !== es || {fwd, tleft, tright} !== ea) begin
      failures++;
      $display("FAIL %s: state=%b act=%b expected state=%b act=%b",
               req, st, {fwd, tleft, tright}, es, ea);
    end
  endtask

  task automatic step(input logic l, input logic r);
    @(negedge clk);
    tl = l; tr = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    chk("R1 reset", 3'b000, 3'b100);
    repeat (3) @(posedge clk);
    @(negedge clk);
    tl = 1'b1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 release edge1", 3'b000, 3'b100);
    @(posedge clk); #1;
    chk("R1 release edge2", 3'b000, 3'b100);
    @(posedge clk); #1;
    chk("R1/R2 edge3 left touch", 3'b001, 3'b010);
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 async entry", 3'b000, 3'b100);
    tl = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R2 R3 R4 R5 R6 R7 vector walk
    for (int i = 0; i < 21; i++) begin
      step(VEC[i][4], VEC[i][3]);
      chk($sformatf("R2-6/R7 vec%0d", i), VEC[i][2:0], exp_act(VEC[i][2:0]));
    end
    // R9: inputs toggle between edges, outputs hold (state SEEK)
    @(negedge clk);
    tl = 1'b1; tr = 1'b1; #1;
    chk("R9 no input feedthrough", 3'b011, 3'b101);
    tl = 1'b0; tr = 1'b0;
    @(posedge clk); #1;
    chk("R5 seek to gap", 3'b100, 3'b101);
    // R8: impose each unused code
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      tl = 1'b1; tr = 1'b1;
      force u0.u_reg.state_q = 3'(c);
      #1;
      chk($sformatf("R8 idle outputs code%0d", c), 3'(c), 3'b000);
      release u0.u_reg.state_q;
      @(posedge clk); #1;
      chk($sformatf("R8 recover code%0d", c), 3'b000, 3'b100);
      step(1'b0, 1'b1);
      chk("R2 right touch", 3'b001, 3'b010);
      step(1'b0, 1'b0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule